// File: doc/BRIEF.md
# Half-Bridge Output-Enable and Fault Supervisor

This block sits between the command register of a six-channel half-bridge driver and its gate drivers. Each cycle it takes the latest 16-bit command word, the hardware inhibit pin and a set of fault flags from the analog side. From these it works out which of the twelve power switches may actually conduct. It also builds the 16-bit status word that the serial link shifts back to the host. The fault flags are supply undervoltage, temperature prewarning, thermal shutdown, per-switch open-load comparators and a per-switch short-circuit disable mask.

Undervoltage is qualified by a tick-driven delay timer. Supply-fail, short-detected and thermal-shutdown conditions are kept in sticky flags. The host clears these flags by writing the command word with its status-reset bit set. Within a bridge, the low-side and high-side switches are interlocked. When open-load detection is selected, each switch's status bit reports either its conduction state or its open-load comparator result, depending on whether that switch is on.

Top module: `hb_supervisor`

## Requirements
- R1: After synchronous reset all sticky flags are clear. With command 0xE000, INH high and no faults, every gate enable, every detection-source enable and every status bit is 0.
- R2: Command bits 1..12 request the switches in the order LS1, HS1, LS2, HS2 … HS6. Request bit k+1 drives `gate_en[k]`. In normal operation (bit 15 high, bit 13 high), status bit k+1 equals `gate_en[k]`.
- R3: When both switches of one bridge are requested, both enables of that bridge are 0. Other bridges are unaffected.
- R4: When command bit 15 is 0 or `inh_pin` is low, all gate enables are 0 and status bit 14 reads 1. When both are high again, the enables return.
- R5: Undervoltage disables the outputs only after it has been present for UV_TICKS consecutive ticks. The supply-fail status bit 15 is set one clock later. An undervoltage that goes away earlier restarts the count.
- R6: When undervoltage clears, the outputs are re-enabled in the same cycle. Status bit 15 stays 1 until a status-reset write: `cmd_strobe` high with command bit 0 set.
- R7: Thermal shutdown turns off every gate enable and makes the status word 0xFFFF. It is released only by a status-reset write made while `tsd_flag` is low.
- R8: Status bit 0 follows `tp_flag` in the same cycle.
- R9: A switch whose `short_mask` bit is high is not enabled. Any set mask bit sets the sticky status bit 13, which is cleared by a status-reset write.
- R10: With command bit 13 low, detection sources are enabled on every switch that is off. The status bit of an off switch then shows its `ol_cmp` bit, and an on switch reads 1. With bit 13 high, sources are off and `ol_cmp` has no effect on the status.
- R11: When a status-reset write meets a fault that is still present (undervoltage already past its delay, or `tsd_flag` high), the fault flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | 16 | Current command word |
| cmd_strobe | input | 1 | One-cycle pulse marking a new command write |
| inh_pin | input | 1 | Hardware inhibit, low = standby |
| uv_flag | input | 1 | Supply undervoltage comparator |
| tp_flag | input | 1 | Temperature prewarning comparator (hysteresis external) |
| tsd_flag | input | 1 | Thermal shutdown comparator |
| ol_cmp | input | 12 | Open-load comparator per switch |
| short_mask | input | 12 | Per-switch short-circuit disable from the short timer |
| tick | input | 1 | Time-base pulse for the undervoltage delay |
| gate_en | output | 12 | Final gate enables, even = low side, odd = high side |
| ol_src_en | output | 12 | Open-load detection current-source enables |
| status_word | output | 16 | Status word returned to the host |

## Verification
The hardest situation to reach is a status-reset write that collides with a fault that is still active. This happens when undervoltage has just passed its delay or the shutdown comparator is still high. It needs the tick count, the comparator level and the strobe to line up in one exact cycle. The stimulus holds `tick` high so the delay advances one count per clock. It strobes the reset on the cycle after the trip is visible at the enables, and for thermal shutdown it re-raises the flag just before the strobe. It also breaks one undervoltage run short by a single cycle to show that the count restarts.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;

    localparam int NUM_BRIDGE = 6;
    localparam int NUM_SW     = 2 * NUM_BRIDGE;
    localparam int WORD_W     = 16;

    // Command word layout (bit 0 upwards): status reset, switch requests, detection-off, delay select, run
    typedef struct packed {
        logic              run;
        logic              sct;
        logic              ol_off;
        logic [NUM_SW-1:0] req;
        logic              srst;
    } cmd_t;

    // Status word layout (bit 0 upwards): prewarning, switch states, short, inhibit, supply fail
    typedef struct packed {
        logic              psf;
        logic              inh;
        logic              scd;
        logic [NUM_SW-1:0] sw;
        logic              tp;
    } stat_t;

    function automatic int ls_idx(input int bridge);
        return 2 * bridge;
    endfunction

    function automatic int hs_idx(input int bridge);
        return 2 * bridge + 1;
    endfunction

endpackage

// File: rtl/hb_uv_timer.sv
module hb_uv_timer #(
    parameter int UV_TICKS = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_in,
    input  logic tick,
    output logic uv_trip
);
    localparam int CW = $clog2(UV_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(UV_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!uv_in) begin
            cnt <= '0;
        end else if (tick && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign uv_trip = uv_in && (cnt == LIMIT);

    // R5: a gap in undervoltage restarts the delay
    assert_uv_restart_R5: assert property (@(posedge clk) disable iff (rst)
        !uv_in |=> (cnt == '0));

    // R5: the count never passes its limit
    assert_uv_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    // R11: a present fault beats a clear request
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R6, R7, R9: flags only fall on a clear
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/hb_bridge_gate.sv
module hb_bridge_gate (
    input  logic       run,
    input  logic       ol_mode,
    input  logic [1:0] req,
    input  logic [1:0] mask,
    input  logic [1:0] ol_cmp,
    output logic [1:0] en,
    output logic [1:0] src,
    output logic [1:0] st
);
    logic conflict;

    always_comb begin
        conflict = &req;
        en  = (run && !conflict) ? (req & ~mask) : 2'b00;
        src = ol_mode ? ~en : 2'b00;
        for (int j = 0; j < 2; j++) begin
            st[j] = (ol_mode && !en[j]) ? ol_cmp[j] : en[j];
        end
    end

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
    import hb_sup_pkg::*;
#(
    parameter int UV_TICKS = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              cmd_strobe,
    input  logic              inh_pin,
    input  logic              uv_flag,
    input  logic              tp_flag,
    input  logic              tsd_flag,
    input  logic [NUM_SW-1:0] ol_cmp,
    input  logic [NUM_SW-1:0] short_mask,
    input  logic              tick,
    output logic [NUM_SW-1:0] gate_en,
    output logic [NUM_SW-1:0] ol_src_en,
    output logic [WORD_W-1:0] status_word
);
    cmd_t  cmd;
    stat_t stat;
    logic  uv_trip, psf_q, scd_q, tsd_q;
    logic  status_clr, run, standby, ol_mode;
    logic  unused_sct;
    logic [NUM_SW-1:0] sw_state;

    assign cmd        = cmd_t'(cmd_word);
    assign unused_sct = cmd.sct;
    assign status_clr = cmd_strobe && cmd.srst;
    assign standby    = !cmd.run || !inh_pin;
    assign ol_mode    = !cmd.ol_off;
    assign run        = !standby && !uv_trip && !tsd_q;

    hb_uv_timer #(.UV_TICKS(UV_TICKS)) u_uv (
        .clk(clk), .rst(rst), .uv_in(uv_flag), .tick(tick), .uv_trip(uv_trip)
    );

    hb_fault_latch u_psf (
        .clk(clk), .rst(rst), .set_i(uv_trip), .clr_i(status_clr), .flag_o(psf_q)
    );

    hb_fault_latch u_scd (
        .clk(clk), .rst(rst), .set_i(|short_mask), .clr_i(status_clr), .flag_o(scd_q)
    );

    hb_fault_latch u_tsd (
        .clk(clk), .rst(rst), .set_i(tsd_flag), .clr_i(status_clr), .flag_o(tsd_q)
    );

    for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_bridge
        localparam int L = ls_idx(b);
        localparam int H = hs_idx(b);

        hb_bridge_gate u_gate (
            .run    (run),
            .ol_mode(ol_mode),
            .req    ({cmd.req[H], cmd.req[L]}),
            .mask   ({short_mask[H], short_mask[L]}),
            .ol_cmp ({ol_cmp[H], ol_cmp[L]}),
            .en     ({gate_en[H], gate_en[L]}),
            .src    ({ol_src_en[H], ol_src_en[L]}),
            .st     ({sw_state[H], sw_state[L]})
        );

        // R3: the two switches of one bridge never conduct together
        assert_interlock_R3: assert property (@(posedge clk) disable iff (rst)
            !(gate_en[L] && gate_en[H]));
    end

    always_comb begin
        stat.tp  = tp_flag;
        stat.sw  = sw_state;
        stat.scd = scd_q;
        stat.inh = standby;
        stat.psf = psf_q;
        status_word = tsd_q ? '1 : WORD_W'(stat);
    end

    assert_uv_off_R5: assert property (@(posedge clk) disable iff (rst)
        uv_trip |-> (gate_en == '0));

    assert_tsd_off_R7: assert property (@(posedge clk) disable iff (rst)
        tsd_q |-> (gate_en == '0 && status_word == '1));

    assert_inhibit_R4: assert property (@(posedge clk) disable iff (rst)
        (!inh_pin || !cmd_word[15]) |-> (gate_en == '0));

    assert_short_off_R9: assert property (@(posedge clk) disable iff (rst)
        (gate_en & short_mask) == '0);

endmodule

// File: tb/hb_supervisor_tb.sv
module hb_supervisor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int UVT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cmd_word = 16'hE000;
    logic        cmd_strobe = 1'b0;
    logic        inh_pin = 1'b1;
    logic        uv_flag = 1'b0;
    logic        tp_flag = 1'b0;
    logic        tsd_flag = 1'b0;
    logic [11:0] ol_cmp = '0;
    logic [11:0] short_mask = '0;
    logic        tick = 1'b1;
    logic [11:0] gate_en, ol_src_en;
    logic [15:0] status_word;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hb_supervisor #(.UV_TICKS(UVT)) u_dut (
        .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe),
        .inh_pin(inh_pin), .uv_flag(uv_flag), .tp_flag(tp_flag), .tsd_flag(tsd_flag),
        .ol_cmp(ol_cmp), .short_mask(short_mask), .tick(tick),
        .gate_en(gate_en), .ol_src_en(ol_src_en), .status_word(status_word)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_status();
        cmd_word   = cmd_word | 16'h0001;
        cmd_strobe = 1'b1;
        cyc(1);
        cmd_strobe = 1'b0;
        cmd_word   = cmd_word & 16'hFFFE;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
        chk("R1 gates", {4'h0, gate_en}, 16'h0000);
        chk("R1 sources", {4'h0, ol_src_en}, 16'h0000);
        chk("R1 status", status_word, 16'h0000);
    endtask

    task automatic t_gates();
        cmd_word = 16'hA812; #1;
        chk("R2 mixed gates", {4'h0, gate_en}, 16'h0409);
        chk("R2 mixed status", status_word, 16'h0812);
        cmd_word = 16'hB554; #1;
        chk("R2 high sides gates", {4'h0, gate_en}, 16'h0AAA);
        chk("R2 high sides status", status_word, 16'h1554);
    endtask

    task automatic t_interlock();
        cmd_word = 16'hA00E; #1;
        chk("R3 gates", {4'h0, gate_en}, 16'h0004);
        chk("R3 status", status_word, 16'h0008);
    endtask

    task automatic t_inhibit();
        cmd_word = 16'h2004; #1;
        chk("R4 sw inhibit gates", {4'h0, gate_en}, 16'h0000);
        chk("R4 sw inhibit status", status_word, 16'h4000);
        cmd_word = 16'hA004; inh_pin = 1'b0; #1;
        chk("R4 pin inhibit gates", {4'h0, gate_en}, 16'h0000);
        chk("R4 pin inhibit status", status_word, 16'h4000);
        inh_pin = 1'b1; #1;
        chk("R4 restore gates", {4'h0, gate_en}, 16'h0002);
        chk("R4 restore status", status_word, 16'h0004);
    endtask

    task automatic t_uv();
        @(negedge clk);
        cmd_word = 16'hA002;
        uv_flag = 1'b1;
        cyc(UVT - 1);
        uv_flag = 1'b0;
        cyc(1);
        uv_flag = 1'b1;
        cyc(UVT - 1);
        chk("R5 before delay", {4'h0, gate_en}, 16'h0001);
        cyc(1);
        chk("R5 tripped gates", {4'h0, gate_en}, 16'h0000);
        chk("R5 psf lag", status_word, 16'h0000);
        cyc(1);
        chk("R5 psf set", status_word, 16'h8000);
        clear_status();
        chk("R11 psf survives clear", status_word, 16'h8000);
        uv_flag = 1'b0; #1;
        chk("R6 immediate return", {4'h0, gate_en}, 16'h0001);
        chk("R6 psf sticky", status_word, 16'h8002);
        cyc(2);
        chk("R6 psf still sticky", status_word, 16'h8002);
        clear_status();
        chk("R6 psf cleared", status_word, 16'h0002);
    endtask

    task automatic t_tsd();
        tsd_flag = 1'b1;
        cyc(1);
        chk("R7 gates off", {4'h0, gate_en}, 16'h0000);
        chk("R7 status ones", status_word, 16'hFFFF);
        tsd_flag = 1'b0;
        cyc(2);
        chk("R7 held without clear", status_word, 16'hFFFF);
        tsd_flag = 1'b1;
        clear_status();
        chk("R11 tsd survives clear", status_word, 16'hFFFF);
        tsd_flag = 1'b0;
        clear_status();
        chk("R7 released status", status_word, 16'h0002);
        chk("R7 released gates", {4'h0, gate_en}, 16'h0001);
    endtask

    task automatic t_tp();
        tp_flag = 1'b1; #1;
        chk("R8 prewarn on", status_word, 16'h0003);
        tp_flag = 1'b0; #1;
        chk("R8 prewarn off", status_word, 16'h0002);
    endtask

    task automatic t_short();
        cmd_word = 16'hA00A;
        short_mask = 12'h001; #1;
        chk("R9 masked gate", {4'h0, gate_en}, 16'h0004);
        cyc(1);
        chk("R9 scd set", status_word, 16'h2008);
        short_mask = 12'h000; #1;
        chk("R9 unmasked gates", {4'h0, gate_en}, 16'h0005);
        chk("R9 scd sticky", status_word, 16'h200A);
        clear_status();
        chk("R9 scd cleared", status_word, 16'h000A);
    endtask

    task automatic t_openload();
        cmd_word = 16'h8002;
        ol_cmp = 12'h0F1; #1;
        chk("R10 sources", {4'h0, ol_src_en}, 16'h0FFE);
        chk("R10 status", status_word, 16'h01E2);
        ol_cmp = 12'h0F0; #1;
        chk("R10 on switch reads on", status_word, 16'h01E2);
        cmd_word = 16'hA002; #1;
        chk("R10 sources off", {4'h0, ol_src_en}, 16'h0000);
        chk("R10 comparators ignored", status_word, 16'h0002);
        ol_cmp = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_gates();
        t_interlock();
        t_inhibit();
        t_uv();
        t_tsd();
        t_tp();
        t_short();
        t_openload();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule